// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns one burst command into a stream of beat addresses. A command carries a start address, a length field (the beat count minus one), a size field (log2 of the bytes moved per beat) and a two-bit kind. Once accepted, the block presents one beat at a time. Each beat has an address and a flag that marks the final beat. The consumer takes a beat by raising its ready signal while the beat is valid.

Three address walks are supported. A fixed walk repeats the start address. A linear walk adds the beat size to the address on every beat. A folding walk stays inside an aligned window whose size is the beat size times the beat count, and returns to the window base after its top. A fold request with a beat count the window logic cannot use is reported on an error output and walked linearly instead. The block holds one burst at a time. It takes the next command only in the cycle after the final beat has been consumed.

Top module: `burst_beat_addr_gen`

## Requirements
- R1: After reset, cmd_ready is 1, beat_valid is 0 and wrap_err is 0.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. From the next cycle beat_valid is 1 and beat_addr equals the command's start address.
- R3: A burst presents exactly cmd_len+1 beats. beat_last is 1 on the final beat only.
- R4: With cmd_kind 2'b00 (fixed), every beat address equals the start address.
- R5: With cmd_kind 2'b01 (linear), beat i has address start + i*2^cmd_size, modulo 2^ADDR_W.
- R6: With cmd_kind 2'b10 (fold) and a beat count of 2, 4, 8 or 16, let span be 2^cmd_size*(cmd_len+1) and base be start rounded down to a multiple of span. Beat i then has address base + ((start + i*2^cmd_size) mod span).
- R7: cmd_kind 2'b11 produces the same addresses as 2'b01.
- R8: With cmd_kind 2'b10 and any other beat count, wrap_err is 1 for the whole burst and the addresses follow R5. In every other case wrap_err is 0.
- R9: While beat_valid is 1 and beat_ready is 0, beat_addr, beat_last and wrap_err hold their values.
- R10: From the cycle after a command is taken until the final beat is consumed, cmd_ready is 0. Commands offered during that time are neither taken nor do they alter the burst.
- R11: In the cycle after the final beat is consumed, beat_valid is 0 and cmd_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and can take a command |
| cmd_addr | input | ADDR_W | Start address |
| cmd_len | input | LEN_W | Beat count minus one |
| cmd_size | input | SIZE_W | log2 of bytes per beat |
| cmd_kind | input | 2 | 00 fixed, 01 linear, 10 fold, 11 linear |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | Consumer takes the presented beat |
| beat_addr | output | ADDR_W | Address of the presented beat |
| beat_last | output | 1 | Presented beat is the final one |
| wrap_err | output | 1 | Fold requested with an unusable beat count |

## Verification
The visible state is small: the current address, the beat counter, the captured walk, the step and mask, and the busy and error bits. A wrong value in any of them shows at the ports by the next consumed beat. A corrupt step or mask moves the second beat's address. A wrong counter moves beat_last or changes the beat count. A stuck busy bit breaks the alternation between cmd_ready and beat_valid within one cycle of the final beat. The bench sweeps every kind, every length and every size of a small configuration across edge start addresses, with stalls at random points. It also offers a conflicting command during each burst.

// File: rtl/bbag_pkg.sv
package bbag_pkg;
  typedef enum logic [1:0] {
    KIND_FIXED  = 2'b00,
    KIND_LINEAR = 2'b01,
    KIND_FOLD   = 2'b10,
    KIND_SPARE  = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    WALK_HOLD   = 2'b00,
    WALK_LINEAR = 2'b01,
    WALK_FOLD   = 2'b10
  } walk_e;
endpackage

// File: rtl/bbag_decode.sv
module bbag_decode
  import bbag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic [1:0]        kind,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  output walk_e             walk,
  output logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] mask,
  output logic              bad_wrap
);
  localparam logic [ADDR_W-1:0] A_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  // bytes moved by one beat
  function automatic logic [ADDR_W-1:0] bytes_of(input logic [SIZE_W-1:0] sz);
    return A_ONE << sz;
  endfunction

  // low-bit mask of the fold window: beats * bytes - 1
  function automatic logic [ADDR_W-1:0] span_mask(input logic [LEN_W-1:0] ln,
                                                  input logic [SIZE_W-1:0] sz);
    logic [ADDR_W-1:0] beats;
    beats = ADDR_W'(ln) + A_ONE;
    return (beats << sz) - A_ONE;
  endfunction

  // fold needs 2, 4, 8 or 16 beats
  function automatic logic fold_len_ok(input logic [LEN_W-1:0] ln);
    return (ln == LEN_W'(1)) || (ln == LEN_W'(3)) ||
           (ln == LEN_W'(7)) || (ln == LEN_W'(15));
  endfunction

  always_comb begin
    step     = bytes_of(size);
    mask     = span_mask(len, size);
    bad_wrap = 1'b0;
    case (kind_e'(kind))
      KIND_FIXED: walk = WALK_HOLD;
      KIND_FOLD: begin
        if (fold_len_ok(len)) begin
          walk = WALK_FOLD;
        end else begin
          walk     = WALK_LINEAR;
          bad_wrap = 1'b1;
        end
      end
      default: walk = WALK_LINEAR;
    endcase
  end
endmodule

// File: rtl/bbag_step.sv
module bbag_step
  import bbag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  walk_e             walk,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] step,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] nxt
);
  function automatic logic [ADDR_W-1:0] next_addr(input walk_e w,
                                                  input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] s,
                                                  input logic [ADDR_W-1:0] m);
    logic [ADDR_W-1:0] sum;
    sum = a + s;
    case (w)
      WALK_HOLD: return a;
      WALK_FOLD: return (a & ~m) | (sum & m);
      default:   return sum;
    endcase
  endfunction

  always_comb nxt = next_addr(walk, cur, step, mask);
endmodule

// File: rtl/bbag_count.sv
module bbag_count #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [LEN_W-1:0] len_in,
  output logic             last
);
  localparam logic [LEN_W-1:0] L_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      lim_q <= len_in;
    end else if (adv) begin
      cnt_q <= cnt_q + L_ONE;
    end
  end

  assign last = (cnt_q == lim_q);
endmodule

// File: rtl/burst_beat_addr_gen.sv
module burst_beat_addr_gen
  import bbag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [1:0]        cmd_kind,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last,
  output logic              wrap_err
);
  // decoded command
  walk_e             dec_walk;
  logic [ADDR_W-1:0] dec_step;
  logic [ADDR_W-1:0] dec_mask;
  logic              dec_bad;

  // burst state
  logic              busy_q;
  logic              err_q;
  walk_e             walk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] step_q;
  logic [ADDR_W-1:0] mask_q;

  // named events
  logic              take_cmd;
  logic              beat_fire;
  logic              burst_end;
  logic              cnt_last;
  logic [ADDR_W-1:0] nxt_addr;

  bbag_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_dec (
    .kind     (cmd_kind),
    .len      (cmd_len),
    .size     (cmd_size),
    .walk     (dec_walk),
    .step     (dec_step),
    .mask     (dec_mask),
    .bad_wrap (dec_bad)
  );

  bbag_step #(.ADDR_W(ADDR_W)) u_step (
    .walk (walk_q),
    .cur  (addr_q),
    .step (step_q),
    .mask (mask_q),
    .nxt  (nxt_addr)
  );

  bbag_count #(.LEN_W(LEN_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (take_cmd),
    .adv    (beat_fire),
    .len_in (cmd_len),
    .last   (cnt_last)
  );

  assign cmd_ready  = !busy_q;
  assign beat_valid = busy_q;
  assign beat_addr  = addr_q;
  assign beat_last  = busy_q && cnt_last;
  assign wrap_err   = err_q;

  assign take_cmd  = cmd_valid && cmd_ready;
  assign beat_fire = beat_valid && beat_ready;
  assign burst_end = beat_fire && beat_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      walk_q <= WALK_HOLD;
      addr_q <= '0;
      step_q <= '0;
      mask_q <= '0;
    end else if (take_cmd) begin
      busy_q <= 1'b1;
      err_q  <= dec_bad;
      walk_q <= dec_walk;
      addr_q <= cmd_addr;
      step_q <= dec_step;
      mask_q <= dec_mask;
    end else if (burst_end) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (beat_fire) begin
      addr_q <= nxt_addr;
    end
  end
endmodule

// File: rtl/bbag_checker.sv
module bbag_checker
  import bbag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_ready,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              beat_last,
  input logic              wrap_err,
  input walk_e             walk_q,
  input logic              take_cmd,
  input logic              burst_end
);
  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd |=> beat_valid && (beat_addr == $past(cmd_addr)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr)
      && $stable(beat_last) && $stable(wrap_err));

  // R10
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({cmd_ready, beat_valid}));

  // R11
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !beat_valid && cmd_ready);

  // R4
  fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last && (walk_q == WALK_HOLD)
      |=> beat_addr == $past(beat_addr));

  // R8
  err_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_err |-> beat_valid);
endmodule

bind burst_beat_addr_gen bbag_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_addr   (cmd_addr),
  .cmd_ready  (cmd_ready),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_addr  (beat_addr),
  .beat_last  (beat_last),
  .wrap_err   (wrap_err),
  .walk_q     (walk_q),
  .take_cmd   (take_cmd),
  .burst_end  (burst_end)
);

// File: tb/burst_beat_addr_gen_test.sv
`timescale 1ns/1ps
module burst_beat_addr_gen_test;
  localparam int AW = 8;
  localparam int LW = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [SW-1:0] cmd_size = '0;
  logic [1:0]    cmd_kind = '0;
  logic          beat_valid;
  logic          beat_ready = 1'b0;
  logic [AW-1:0] beat_addr;
  logic          beat_last;
  logic          wrap_err;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  burst_beat_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .SIZE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size),
    .cmd_kind(cmd_kind), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beat_last(beat_last), .wrap_err(wrap_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit fold_ok(input int kind, input int len);
    int beats = len + 1;
    return (kind == 2) && (beats == 2 || beats == 4 || beats == 8 || beats == 16);
  endfunction

  function automatic int exp_addr(input int kind, input int start, input int len,
                                  input int size, input int i);
    int bytes = 1 << size;
    if (kind == 0) return start;
    if (fold_ok(kind, len)) begin
      int span = bytes * (len + 1);
      int base = (start / span) * span;
      return base + ((start + i * bytes) % span);
    end
    return (start + i * bytes) % (1 << AW);
  endfunction

  function automatic string addr_req(input int kind, input int len);
    if (kind == 0) return "R4";
    if (kind == 1) return "R5";
    if (kind == 3) return "R7";
    if (fold_ok(kind, len)) return "R6";
    return "R8";
  endfunction

  task automatic run_cmd(input int kind, input int start, input int len, input int size);
    bit done = 0;
    int i = 0;
    bit held_pending = 0;
    int held = 0;
    bit exp_err = (kind == 2) && !fold_ok(kind, len);
    cmd_kind  = 2'(kind);
    cmd_addr  = AW'(start);
    cmd_len   = LW'(len);
    cmd_size  = SW'(size);
    cmd_valid = 1'b1;
    chk(cmd_ready === 1'b1, "R2", cmd_ready, 1);
    @(posedge clk);
    @(negedge clk);
    // conflicting command offered during the burst (R10)
    cmd_kind = 2'(kind ^ 1);
    cmd_addr = AW'(~start);
    cmd_len  = LW'(~len);
    cmd_size = SW'(~size);
    while (!done) begin
      bit rdy = lfsr[0] | lfsr[1];
      beat_ready = rdy;
      chk(beat_valid === 1'b1, "R3", beat_valid, 1);
      chk(cmd_ready === 1'b0, "R10", cmd_ready, 0);
      if (held_pending) chk(int'(beat_addr) == held, "R9", beat_addr, held);
      held_pending = 0;
      if (rdy) begin
        int e = exp_addr(kind, start, len, size, i);
        chk(int'(beat_addr) == e, addr_req(kind, len), beat_addr, e);
        chk(beat_last === (i == len), "R3", beat_last, (i == len));
        chk(wrap_err === exp_err, "R8", wrap_err, exp_err);
        if (i == len) done = 1;
        i++;
      end else begin
        held_pending = 1;
        held = int'(beat_addr);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(posedge clk);
      @(negedge clk);
    end
    beat_ready = 1'b0;
    cmd_valid  = 1'b0;
    chk(beat_valid === 1'b0, "R11", beat_valid, 0);
    chk(cmd_ready === 1'b1, "R11", cmd_ready, 1);
    @(posedge clk);
    @(negedge clk);
    chk(beat_valid === 1'b0, "R10", beat_valid, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int starts[6] = '{0, 'h13, 'h7D, 'hF6, 'hFF, 'h40};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cmd_ready === 1'b1, "R1", cmd_ready, 1);
    chk(beat_valid === 1'b0, "R1", beat_valid, 0);
    chk(wrap_err === 1'b0, "R1", wrap_err, 0);
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++)
        for (int l = 0; l < 16; l++)
          for (int a = 0; a < 6; a++)
            run_cmd(k, starts[a], l, s);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule